// File: doc/BRIEF.md
# Privileged Trap Entry and Return Sequencer

This block carries out the hardware steps that move a processor from user code into privileged code when a software interrupt, a page fault or an external interrupt is taken. It also carries out the steps that undo the move. For an entry, the block takes a vector number and reads a two-word gate record. The gate record sits in a table whose base address is a register input. The block compares the current privilege level with the privilege level of the gate. It then fetches the kernel stack pointer and stack segment from a task-state record and saves the interrupted context on that kernel stack. Last, it presents the new context: some flag bits cleared, and the code selector and instruction pointer taken from the gate.

A return request pops the same five words in the opposite order from the current stack. It presents them as the resumed context and takes the privilege level from the low bits of the popped code selector. All memory traffic goes through one request/acknowledge port. A request stays asserted until it is acknowledged.

The control is one state machine with these states:
- IDLE: waits for a request.
- GATE_LO, GATE_HI: read the two gate words.
- PRIV: compares the privilege levels.
- TSS_SP, TSS_SS: read the kernel stack values.
- PUSH: writes the five context words.
- ENTER: presents the new context.
- FAULT: reports a refused entry.
- POP: reads the five saved words.
- LEAVE: presents the resumed context.

The transitions are:
- IDLE to GATE_LO on an entry request.
- IDLE to POP on a return request.
- GATE_LO to GATE_HI to PRIV as each read is acknowledged.
- PRIV to TSS_SP when the check passes, or PRIV to FAULT when it fails.
- TSS_SP to TSS_SS to PUSH as each read is acknowledged.
- PUSH to ENTER after the fifth write.
- POP to LEAVE after the fifth read.
- ENTER, FAULT and LEAVE back to IDLE.

Top module: `trap_seq`

## Requirements
- R1: After reset, busy, ctx_valid, gp_fault and mem_req are 0, and priv_level is 0 (privileged).
- R2: An entry reads the gate at gate_base + 8*vector. Word 0 is the target instruction pointer. In word 1, bits 31:16 hold the target code selector and bits 14:13 hold the gate privilege level.
- R3: When priv_level is greater than the gate privilege level, gp_fault pulses for one cycle. The block then makes no memory write and no ctx_valid, and priv_level keeps its value.
- R4: When priv_level is less than or equal to the gate privilege level, the block reads the kernel stack pointer at tss_base+4 and then the kernel stack segment at tss_base+8.
- R5: The entry writes five words. Each write address is 4 below the previous one, starting at kernel stack pointer minus 4. The words, in order, are the interrupted stack segment, stack pointer, flags, code selector and instruction pointer.
- R6: At the end of an entry, ctx_valid pulses with ctx_entry=1 and presents these values. ctx_ss is the kernel segment. ctx_esp is the kernel stack pointer minus 20. ctx_eflags is the interrupted flags with bit 9 (interrupt enable) and bit 8 (trap) cleared. ctx_cs and ctx_eip come from the gate.
- R7: From the cycle after an entry's ctx_valid, priv_level is 0.
- R8: A return reads five words at cur_esp, cur_esp+4, … cur_esp+16, taking them as instruction pointer, code selector, flags, stack pointer and stack segment. It then pulses ctx_valid with ctx_entry=0 and those values. It makes no write. From the next cycle, priv_level equals bits 1:0 of the popped code selector.
- R9: busy is 1 in every cycle of a sequence, including the ctx_valid or gp_fault cycle, and 0 otherwise. Requests that arrive while busy is 1 are ignored.
- R10: If an entry request and a return request arrive in the same idle cycle, the entry is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_req | input | 1 | Start an entry sequence |
| trap_vec | input | 8 | Vector number for the entry |
| ret_req | input | 1 | Start a return sequence |
| gate_base | input | 32 | Base address of the gate table |
| tss_base | input | 32 | Base address of the task-state record |
| cur_ss | input | 32 | Stack segment of the running context |
| cur_esp | input | 32 | Stack pointer of the running context |
| cur_eflags | input | 32 | Flags of the running context |
| cur_cs | input | 32 | Code selector of the running context |
| cur_eip | input | 32 | Instruction pointer of the running context |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current request |
| busy | output | 1 | A sequence is in progress |
| gp_fault | output | 1 | Entry refused by the privilege check |
| ctx_valid | output | 1 | New context presented on ctx_* |
| ctx_entry | output | 1 | 1 = the context comes from an entry, 0 = from a return |
| ctx_ss | output | 32 | New stack segment |
| ctx_esp | output | 32 | New stack pointer |
| ctx_eflags | output | 32 | New flags |
| ctx_cs | output | 32 | New code selector |
| ctx_eip | output | 32 | New instruction pointer |
| priv_level | output | 2 | Current privilege level |

## Verification
The hardest situation to reach is an entry made from user privilege, because the block leaves reset at privilege 0. The stimulus first stages a saved frame in memory and issues a return whose popped selector carries level 3. This moves the block into user mode and checks the return path. Entries to a level-3 gate and to a level-0 gate are then attempted from that state, so one passes the check and one faults. The frame just pushed is then popped back to confirm that the save order and the restore order match.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned PRIV_W      = 2;
    localparam int unsigned FRAME_WORDS = 5;
    localparam int unsigned IDX_W       = $clog2(FRAME_WORDS);

    // flag bits cleared on entry
    localparam int unsigned IE_BIT = 9;
    localparam int unsigned TR_BIT = 8;

    // frame slot indices, in push order
    localparam logic [IDX_W-1:0] SLOT_SS  = 3'd0;
    localparam logic [IDX_W-1:0] SLOT_ESP = 3'd1;
    localparam logic [IDX_W-1:0] SLOT_FLG = 3'd2;
    localparam logic [IDX_W-1:0] SLOT_CS  = 3'd3;
    localparam logic [IDX_W-1:0] SLOT_EIP = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_GATE_LO,
        S_GATE_HI,
        S_PRIV,
        S_TSS_SP,
        S_TSS_SS,
        S_PUSH,
        S_ENTER,
        S_FAULT,
        S_POP,
        S_LEAVE
    } seq_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] target_ip;
        logic [15:0]       target_sel;
        logic [PRIV_W-1:0] gate_priv;
    } gate_t;

endpackage

// File: rtl/trap_priv_check.sv
module trap_priv_check #(
    parameter int unsigned PW = 2
) (
    input  logic [PW-1:0] run_level,
    input  logic [PW-1:0] gate_level,
    output logic          allow
);
    // lower number = more privilege; entry allowed when running level <= gate level
    always_comb begin
        allow = (run_level <= gate_level);
    end
endmodule

// File: rtl/trap_frame_store.sv
module trap_frame_store #(
    parameter int unsigned DW = 32,
    parameter int unsigned N  = 5,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snap,
    input  logic [N*DW-1:0]    snap_words,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic [IW-1:0]      rd_idx,
    output logic [DW-1:0]      rd_data,
    output logic [N*DW-1:0]    all_words
);
    logic [DW-1:0] slot_q [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (snap) begin
                slot_q[g] <= snap_words[g*DW +: DW];
            end else if (wr_en && (wr_idx == IW'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
        assign all_words[g*DW +: DW] = slot_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N; k++) begin
            if (rd_idx == IW'(k)) begin
                rd_data = slot_q[k];
            end
        end
    end
endmodule

// File: rtl/trap_sp_unit.sv
module trap_sp_unit #(
    parameter int unsigned DW   = 32,
    parameter int unsigned STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          dec,
    input  logic          inc,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] sp_minus
);
    logic [DW-1:0] sp_q;

    assign sp_minus = sp_q - DW'(STEP);
    assign sp       = sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (load) begin
            sp_q <= load_val;
        end else if (dec) begin
            sp_q <= sp_minus;
        end else if (inc) begin
            sp_q <= sp_q + DW'(STEP);
        end
    end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_seq_pkg::*;
#(
    parameter int unsigned VEC_W        = 8,
    parameter int unsigned GATE_BYTES   = 8,
    parameter int unsigned TSS_SP_OFS   = 4,
    parameter int unsigned TSS_SEG_OFS  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trap_req,
    input  logic [VEC_W-1:0]    trap_vec,
    input  logic                ret_req,
    input  logic [WORD_W-1:0]   gate_base,
    input  logic [WORD_W-1:0]   tss_base,
    input  logic [WORD_W-1:0]   cur_ss,
    input  logic [WORD_W-1:0]   cur_esp,
    input  logic [WORD_W-1:0]   cur_eflags,
    input  logic [WORD_W-1:0]   cur_cs,
    input  logic [WORD_W-1:0]   cur_eip,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                mem_ack,
    output logic                busy,
    output logic                gp_fault,
    output logic                ctx_valid,
    output logic                ctx_entry,
    output logic [WORD_W-1:0]   ctx_ss,
    output logic [WORD_W-1:0]   ctx_esp,
    output logic [WORD_W-1:0]   ctx_eflags,
    output logic [WORD_W-1:0]   ctx_cs,
    output logic [WORD_W-1:0]   ctx_eip,
    output logic [PRIV_W-1:0]   priv_level
);
    localparam int unsigned GATE_SHIFT = $clog2(GATE_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);
    localparam logic [WORD_W-1:0] CLR_MASK =
        ~((WORD_W'(1) << IE_BIT) | (WORD_W'(1) << TR_BIT));

    seq_state_t state_q, state_d;

    gate_t              gate_q;
    logic [WORD_W-1:0]  kseg_q;
    logic [PRIV_W-1:0]  cpl_q;
    logic [IDX_W-1:0]   cnt_q;
    logic [WORD_W-1:0]  gate_addr;

    logic               chk_allow;
    logic               sp_load, sp_dec, sp_inc;
    logic [WORD_W-1:0]  sp_now, sp_next_dn;
    logic               fr_snap, fr_wr;
    logic [IDX_W-1:0]   fr_wr_idx;
    logic [WORD_W-1:0]  fr_rd;
    logic [FRAME_WORDS*WORD_W-1:0] fr_all, fr_snap_words;

    assign gate_addr = gate_base + (WORD_W'(trap_vec) << GATE_SHIFT);

    // ---------------- submodules ----------------
    trap_priv_check #(.PW(PRIV_W)) u_chk (
        .run_level  (cpl_q),
        .gate_level (gate_q.gate_priv),
        .allow      (chk_allow)
    );

    trap_sp_unit #(.DW(WORD_W), .STEP(4)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sp_load),
        .load_val ((state_q == S_IDLE) ? cur_esp : mem_rdata),
        .dec      (sp_dec),
        .inc      (sp_inc),
        .sp       (sp_now),
        .sp_minus (sp_next_dn)
    );

    assign fr_snap_words = {cur_eip, cur_cs, cur_eflags, cur_esp, cur_ss};

    trap_frame_store #(.DW(WORD_W), .N(FRAME_WORDS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .snap       (fr_snap),
        .snap_words (fr_snap_words),
        .wr_en      (fr_wr),
        .wr_idx     (fr_wr_idx),
        .wr_data    (mem_rdata),
        .rd_idx     (cnt_q),
        .rd_data    (fr_rd),
        .all_words  (fr_all)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (trap_req)      state_d = S_GATE_LO;
                else if (ret_req)  state_d = S_POP;
            end
            S_GATE_LO: if (mem_ack) state_d = S_GATE_HI;
            S_GATE_HI: if (mem_ack) state_d = S_PRIV;
            S_PRIV:    state_d = chk_allow ? S_TSS_SP : S_FAULT;
            S_TSS_SP:  if (mem_ack) state_d = S_TSS_SS;
            S_TSS_SS:  if (mem_ack) state_d = S_PUSH;
            S_PUSH:    if (mem_ack && cnt_q == LAST_IDX) state_d = S_ENTER;
            S_ENTER:   state_d = S_IDLE;
            S_FAULT:   state_d = S_IDLE;
            S_POP:     if (mem_ack && cnt_q == LAST_IDX) state_d = S_LEAVE;
            S_LEAVE:   state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // ---------------- outputs and datapath controls ----------------
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        gp_fault   = 1'b0;
        ctx_valid  = 1'b0;
        ctx_entry  = 1'b0;
        ctx_ss     = '0;
        ctx_esp    = '0;
        ctx_eflags = '0;
        ctx_cs     = '0;
        ctx_eip    = '0;
        sp_load    = 1'b0;
        sp_dec     = 1'b0;
        sp_inc     = 1'b0;
        fr_snap    = 1'b0;
        fr_wr      = 1'b0;
        fr_wr_idx  = LAST_IDX - cnt_q;
        busy       = (state_q != S_IDLE);
        unique case (state_q)
            S_IDLE: begin
                fr_snap = trap_req;
                sp_load = ret_req && !trap_req;
            end
            S_GATE_LO: begin
                mem_req  = 1'b1;
                mem_addr = gate_addr;
            end
            S_GATE_HI: begin
                mem_req  = 1'b1;
                mem_addr = gate_addr + WORD_W'(4);
            end
            S_PRIV: begin
            end
            S_TSS_SP: begin
                mem_req  = 1'b1;
                mem_addr = tss_base + WORD_W'(TSS_SP_OFS);
                sp_load  = mem_ack;
            end
            S_TSS_SS: begin
                mem_req  = 1'b1;
                mem_addr = tss_base + WORD_W'(TSS_SEG_OFS);
            end
            S_PUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_next_dn;
                mem_wdata = fr_rd;
                sp_dec    = mem_ack;
            end
            S_ENTER: begin
                ctx_valid  = 1'b1;
                ctx_entry  = 1'b1;
                ctx_ss     = kseg_q;
                ctx_esp    = sp_now;
                ctx_eflags = fr_all[SLOT_FLG*WORD_W +: WORD_W] & CLR_MASK;
                ctx_cs     = WORD_W'(gate_q.target_sel);
                ctx_eip    = gate_q.target_ip;
            end
            S_FAULT: begin
                gp_fault = 1'b1;
            end
            S_POP: begin
                mem_req  = 1'b1;
                mem_addr = sp_now;
                sp_inc   = mem_ack;
                fr_wr    = mem_ack;
            end
            S_LEAVE: begin
                ctx_valid  = 1'b1;
                ctx_ss     = fr_all[SLOT_SS*WORD_W  +: WORD_W];
                ctx_esp    = fr_all[SLOT_ESP*WORD_W +: WORD_W];
                ctx_eflags = fr_all[SLOT_FLG*WORD_W +: WORD_W];
                ctx_cs     = fr_all[SLOT_CS*WORD_W  +: WORD_W];
                ctx_eip    = fr_all[SLOT_EIP*WORD_W +: WORD_W];
            end
            default: begin
            end
        endcase
    end

    // ---------------- sequencing registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
            kseg_q <= '0;
            cnt_q  <= '0;
            cpl_q  <= '0;
        end else begin
            if (state_q == S_IDLE) begin
                cnt_q <= '0;
            end else if ((state_q == S_PUSH || state_q == S_POP) && mem_ack) begin
                cnt_q <= cnt_q + IDX_W'(1);
            end
            if (state_q == S_GATE_LO && mem_ack) begin
                gate_q.target_ip <= mem_rdata;
            end
            if (state_q == S_GATE_HI && mem_ack) begin
                gate_q.target_sel <= mem_rdata[31:16];
                gate_q.gate_priv  <= mem_rdata[14:13];
            end
            if (state_q == S_TSS_SS && mem_ack) begin
                kseg_q <= mem_rdata;
            end
            if (state_q == S_ENTER) begin
                cpl_q <= '0;
            end else if (state_q == S_LEAVE) begin
                cpl_q <= fr_all[SLOT_CS*WORD_W +: PRIV_W];
            end
        end
    end

    assign priv_level = cpl_q;

endmodule

// File: rtl/trap_seq_checker.sv
module trap_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        trap_req,
    input logic        ret_req,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic        busy,
    input logic        gp_fault,
    input logic        ctx_valid,
    input logic        ctx_entry,
    input logic [31:0] ctx_eflags,
    input logic [31:0] ctx_cs,
    input logic [1:0]  priv_level
);
    logic in_ret_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_ret_q <= 1'b0;
        end else if (!busy) begin
            in_ret_q <= ret_req && !trap_req;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |-> !busy && !mem_req); // R1
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R9
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00); // R5
    AST_ENTRY_FLAGS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_valid && ctx_entry |-> ctx_eflags[9:8] == 2'b00); // R6
    AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_valid && ctx_entry |=> priv_level == 2'd0); // R7
    AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> !mem_req && !ctx_valid); // R3
    AST_FAULT_KEEP_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |=> priv_level == $past(priv_level)); // R3
    AST_RET_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ret_q && mem_req |-> !mem_we); // R8
    AST_RET_PRIV_FROM_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_valid && !ctx_entry |=> priv_level == $past(ctx_cs[1:0])); // R8
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_valid || gp_fault) |-> busy); // R9
endmodule

bind trap_seq trap_seq_checker u_trap_seq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_req   (trap_req),
    .ret_req    (ret_req),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .busy       (busy),
    .gp_fault   (gp_fault),
    .ctx_valid  (ctx_valid),
    .ctx_entry  (ctx_entry),
    .ctx_eflags (ctx_eflags),
    .ctx_cs     (ctx_cs),
    .priv_level (priv_level)
);

// File: tb/trap_seq_test.sv
module trap_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] GATE_BASE = 32'h0000_1000;
    localparam logic [31:0] TSS_BASE  = 32'h0000_2000;
    localparam logic [31:0] KSP0      = 32'h0000_3000;
    localparam logic [31:0] KSEG0     = 32'h0000_0010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_req = 1'b0, ret_req = 1'b0;
    logic [7:0]  trap_vec = '0;
    logic [31:0] cur_ss = '0, cur_esp = '0, cur_eflags = '0, cur_cs = '0, cur_eip = '0;
    logic mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic busy, gp_fault, ctx_valid, ctx_entry;
    logic [31:0] ctx_ss, ctx_esp, ctx_eflags, ctx_cs, ctx_eip;
    logic [1:0]  priv_level;

    logic [31:0] mem [4096];

    int n_vec = 0;
    int n_bad = 0;

    typedef struct { logic [31:0] a; logic [31:0] d; } wr_t;
    wr_t exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_seq uut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_vec(trap_vec),
        .ret_req(ret_req), .gate_base(GATE_BASE), .tss_base(TSS_BASE),
        .cur_ss(cur_ss), .cur_esp(cur_esp), .cur_eflags(cur_eflags),
        .cur_cs(cur_cs), .cur_eip(cur_eip),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .gp_fault(gp_fault), .ctx_valid(ctx_valid),
        .ctx_entry(ctx_entry), .ctx_ss(ctx_ss), .ctx_esp(ctx_esp),
        .ctx_eflags(ctx_eflags), .ctx_cs(ctx_cs), .ctx_eip(ctx_eip),
        .priv_level(priv_level)
    );

    // memory model: acknowledges one cycle after a request is seen
    assign mem_rdata = mem[mem_addr[13:2]];
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_ack <= 1'b0;
        else        mem_ack <= mem_req && !mem_ack;
    end
    always @(posedge clk) begin
        if (mem_req && mem_we && mem_ack) mem[mem_addr[13:2]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: compares every write against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ack) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3/R8 unexpected write addr", mem_addr, 32'h0);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                chk(mem_addr == e.a, "R5 push addr", mem_addr, e.a);
                chk(mem_wdata == e.d, "R5 push data", mem_wdata, e.d);
            end
        end
    end

    task automatic set_ctx(input logic [31:0] ss, esp, fl, cs, ip);
        cur_ss = ss; cur_esp = esp; cur_eflags = fl; cur_cs = cs; cur_eip = ip;
    endtask

    task automatic put_gate(input logic [7:0] v, input logic [31:0] ip,
                            input logic [15:0] sel, input logic [1:0] dpl);
        mem[(GATE_BASE[13:2]) + 12'(v) * 2]     = ip;
        mem[(GATE_BASE[13:2]) + 12'(v) * 2 + 1] = {sel, 1'b1, dpl, 13'h0};
    endtask

    // driver: pulses a request and queues expected pushes
    task automatic start(input bit is_trap, input bit both, input logic [7:0] v, input bit expect_push);
        if (expect_push) begin
            exp_q.push_back('{KSP0 - 4,  cur_ss});
            exp_q.push_back('{KSP0 - 8,  cur_esp});
            exp_q.push_back('{KSP0 - 12, cur_eflags});
            exp_q.push_back('{KSP0 - 16, cur_cs});
            exp_q.push_back('{KSP0 - 20, cur_eip});
        end
        @(negedge clk);
        trap_vec = v;
        trap_req = is_trap;
        ret_req  = !is_trap || both;
        @(negedge clk);
        trap_req = 1'b0;
        ret_req  = 1'b0;
    endtask

    task automatic wait_done(output bit got_ctx, output bit got_fault);
        got_ctx = 0; got_fault = 0;
        for (int i = 0; i < 200; i++) begin
            if (ctx_valid || gp_fault) begin
                got_ctx = ctx_valid; got_fault = gp_fault;
                break;
            end
            // a second request while busy must be ignored (R9)
            if (i == 3) ret_req = 1'b1;
            if (i == 4) ret_req = 1'b0;
            @(negedge clk);
        end
        chk(busy == 1'b1, "R9 busy on completion cycle", 32'(busy), 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog act=0 exp=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        bit c, f;
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        // task-state record
        mem[TSS_BASE[13:2] + 1] = KSP0;
        mem[TSS_BASE[13:2] + 2] = KSEG0;
        put_gate(8'h30, 32'hC000_1000, 16'h0008, 2'd3);
        put_gate(8'h0D, 32'hC000_2000, 16'h0018, 2'd0);
        put_gate(8'hFF, 32'hC000_3000, 16'h0028, 2'd3);
        // staged return frame at 0x800: eip, cs, eflags, esp, ss
        mem[12'h200] = 32'h0040_1234;
        mem[12'h201] = 32'h0000_001B;
        mem[12'h202] = 32'h0000_0302;
        mem[12'h203] = 32'h0000_8000;
        mem[12'h204] = 32'h0000_0023;

        repeat (3) @(negedge clk);
        chk(busy == 0 && mem_req == 0 && ctx_valid == 0 && gp_fault == 0, "R1 reset outputs", {28'h0, busy, mem_req, ctx_valid, gp_fault}, 32'h0);
        chk(priv_level == 2'd0, "R1 reset privilege", 32'(priv_level), 32'h0);
        rst_n = 1'b1;

        // R8: return into user mode from staged frame
        set_ctx(32'h10, 32'h0000_0800, 32'h2, 32'h8, 32'hC000_0000);
        start(1'b0, 1'b0, 8'h00, 1'b0);
        wait_done(c, f);
        chk(c && !ctx_entry, "R8 return completes", 32'({c, ctx_entry}), 32'h2);
        chk(ctx_eip == 32'h0040_1234, "R8 popped eip", ctx_eip, 32'h0040_1234);
        chk(ctx_cs == 32'h1B, "R8 popped cs", ctx_cs, 32'h1B);
        chk(ctx_eflags == 32'h302, "R8 popped eflags", ctx_eflags, 32'h302);
        chk(ctx_esp == 32'h8000, "R8 popped esp", ctx_esp, 32'h8000);
        chk(ctx_ss == 32'h23, "R8 popped ss", ctx_ss, 32'h23);
        @(negedge clk);
        chk(priv_level == 2'd3, "R8 privilege from cs", 32'(priv_level), 32'h3);
        chk(busy == 1'b0, "R9 idle after return", 32'(busy), 32'h0);

        // R3: user entry to a privileged-only gate faults
        set_ctx(32'h23, 32'h8000, 32'h302, 32'h1B, 32'h0040_1234);
        start(1'b1, 1'b0, 8'h0D, 1'b0);
        wait_done(c, f);
        chk(f && !c, "R3 fault raised", 32'({f, c}), 32'h2);
        @(negedge clk);
        chk(gp_fault == 1'b0, "R3 fault one cycle", 32'(gp_fault), 32'h0);
        chk(priv_level == 2'd3, "R3 privilege kept", 32'(priv_level), 32'h3);

        // R2 R4 R5 R6 R10: user entry to level-3 gate, with a return requested in the same cycle
        start(1'b1, 1'b1, 8'h30, 1'b1);
        wait_done(c, f);
        chk(c && ctx_entry, "R10 entry wins", 32'({c, ctx_entry}), 32'h3);
        chk(ctx_eip == 32'hC000_1000, "R2 gate eip", ctx_eip, 32'hC000_1000);
        chk(ctx_cs == 32'h8, "R2 gate selector", ctx_cs, 32'h8);
        chk(ctx_ss == KSEG0, "R4 kernel segment", ctx_ss, KSEG0);
        chk(ctx_esp == KSP0 - 20, "R6 kernel esp", ctx_esp, KSP0 - 20);
        chk(ctx_eflags == 32'h002, "R6 flags cleared", ctx_eflags, 32'h002);
        @(negedge clk);
        chk(priv_level == 2'd0, "R7 kernel after entry", 32'(priv_level), 32'h0);
        chk(busy == 1'b0, "R9 ignored request", 32'(busy), 32'h0);
        chk(exp_q.size() == 0, "R5 all pushes seen", 32'(exp_q.size()), 32'h0);

        // R8: pop the just-pushed frame back
        set_ctx(KSEG0, KSP0 - 20, 32'h002, 32'h8, 32'hC000_1000);
        start(1'b0, 1'b0, 8'h00, 1'b0);
        wait_done(c, f);
        chk(ctx_eip == 32'h0040_1234 && ctx_cs == 32'h1B, "R8 round trip eip/cs", ctx_eip, 32'h0040_1234);
        chk(ctx_esp == 32'h8000 && ctx_ss == 32'h23, "R8 round trip esp/ss", ctx_esp, 32'h8000);
        chk(ctx_eflags == 32'h302, "R8 round trip flags", ctx_eflags, 32'h302);
        @(negedge clk);
        chk(priv_level == 2'd3, "R8 back in user", 32'(priv_level), 32'h3);

        // R2 top vector, equal privilege passes
        set_ctx(32'h23, 32'h7000, 32'h200, 32'h1B, 32'h0040_5678);
        start(1'b1, 1'b0, 8'hFF, 1'b1);
        wait_done(c, f);
        chk(ctx_eip == 32'hC000_3000 && ctx_cs == 32'h28, "R2 vector 255 gate", ctx_eip, 32'hC000_3000);
        chk(ctx_eflags == 32'h0, "R6 interrupt bit cleared", ctx_eflags, 32'h0);
        @(negedge clk);

        // R3 boundary: kernel entry to a level-0 gate passes
        set_ctx(32'h10, 32'h6000, 32'h100, 32'h8, 32'hC000_9000);
        start(1'b1, 1'b0, 8'h0D, 1'b1);
        wait_done(c, f);
        chk(c && !f, "R3 equal level passes", 32'({c, f}), 32'h2);
        chk(ctx_eip == 32'hC000_2000 && ctx_eflags == 32'h0, "R6 trap bit cleared", ctx_eflags, 32'h0);
        @(negedge clk);
        chk(exp_q.size() == 0, "R5 queue drained", 32'(exp_q.size()), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule